// File: doc/BRIEF.md
# Microcode Program Sequencer

This block holds the 12-bit program counter of a microprogrammed stack machine and works out the next microcode address on every rising clock edge. The microcode ROM sits outside it. Each cycle the ROM returns the 8-bit microword stored at the current address, and the sequencer reads that word together with the machine's 8-bit opcode register and eight condition flags to choose the next address.

Four kinds of step are recognised:
- A plain advance by one.
- A jump to one of the sixteen lowest addresses.
- A dispatch that turns the opcode into the base of a 16-word microcode slot.
- A short forward skip that depends on one selected flag.

A dispatch makes every opcode the entry point of its own 16-microword routine. Conditional branches only ever skip forward by a few words, so a microword never has to carry a full target address.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low the address output is 0x000, and it goes there at once when `rst_n` falls, without waiting for a clock edge.
- R2: A microword that is none of the three special forms below moves the address to the current value plus one.
- R3: A microword of the form `1011xxxx` sets the address to `{opcode, 4'b0000}`. Its low four bits have no effect.
- R4: A microword of the form `1001aaaa` sets the address to `{8'h00, aaaa}`.
- R5: A microword of the form `11sssddd` whose selected flag `flags[sss]` is 1 sets the address to the current value plus one plus `ddd`. This covers `ddd` = 0, which gives a plain advance by one.
- R6: A microword of the form `11sssddd` whose selected flag `flags[sss]` is 0 sets the address to the current value plus one.
- R7: In a skip, only the flag bit picked by `sss` takes part. The other seven flag bits have no effect.
- R8: All address arithmetic is modulo 4096. An advance from 0xFFF gives 0x000, and a taken skip past 0xFFF wraps into the bottom of the address space.
- R9: The address output is a register. Changes on `uinstr`, `opcode` or `flags` between clock edges leave it unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the address register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| uinstr | input | 8 | Microword returned by the ROM for the current address |
| opcode | input | 8 | Opcode register; used as the dispatch target |
| flags | input | 8 | Condition flags; one of them is picked by a skip |
| rom_addr | output | 12 | Registered microcode program counter |

## Verification
The counter is the block's only state, and `rom_addr` shows it directly. A wrong next-address choice therefore appears at the port on the first rising edge after the microword that triggered it. From then on, every later address is shifted the same way. Because of this, each step compares the port against a model counter one cycle later, and a single bad step fails at that exact step rather than somewhere further on. The main cases covered are the flag-selection path, the wrap at the top of the address space, and the reset that arrives in the middle of a routine.

// File: rtl/useq_pkg.sv
package useq_pkg;

    // Widths of the sequencer datapath
    localparam int PC_W   = 12;                 // microcode program counter
    localparam int UI_W   = 8;                  // microword
    localparam int OP_W   = 8;                  // opcode register
    localparam int FLAG_W = 8;                  // condition flags

    // Derived field widths
    localparam int SLOT_W = PC_W - OP_W;        // words per dispatch slot (log2)
    localparam int ZP_W   = UI_W - 4;           // zero-page jump field
    localparam int SEL_W  = $clog2(FLAG_W);     // flag select field
    localparam int DIST_W = UI_W - 2 - SEL_W;   // skip distance field

    typedef enum logic [1:0] {
        STEP_NEXT     = 2'd0,
        STEP_DISPATCH = 2'd1,
        STEP_JUMP     = 2'd2,
        STEP_SKIP     = 2'd3
    } step_e;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } seq_state_t;

endpackage

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
(
    input  logic [UI_W-1:0]   ui,
    output step_e             kind,
    output logic [ZP_W-1:0]   jump_addr,
    output logic [SEL_W-1:0]  test_sel,
    output logic [DIST_W-1:0] skip_dist
);

    // The two top bits pick the skip form; otherwise the top nibble
    // picks between dispatch, zero-page jump and plain advance.
    always_comb begin
        if (ui[UI_W-1 -: 2] == 2'b11) begin
            kind = STEP_SKIP;
        end else if (ui[UI_W-1 -: 4] == 4'b1011) begin
            kind = STEP_DISPATCH;
        end else if (ui[UI_W-1 -: 4] == 4'b1001) begin
            kind = STEP_JUMP;
        end else begin
            kind = STEP_NEXT;
        end
    end

    assign jump_addr = ui[ZP_W-1:0];
    assign test_sel  = ui[DIST_W +: SEL_W];
    assign skip_dist = ui[DIST_W-1:0];

endmodule

// File: rtl/useq_flag_sel.sv
module useq_flag_sel
    import useq_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic [SEL_W-1:0]  sel,
    output logic              hit
);

    logic [FLAG_W-1:0] tap;

    // One AND gate per flag, then an OR reduction
    for (genvar g = 0; g < FLAG_W; g++) begin : g_tap
        assign tap[g] = flags[g] & (sel == SEL_W'(g));
    end

    assign hit = |tap;

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [UI_W-1:0]   uinstr,
    input  logic [OP_W-1:0]   opcode,
    input  logic [FLAG_W-1:0] flags,
    output logic [PC_W-1:0]   rom_addr
);

    seq_state_t        st_d, st_q;
    step_e             kind;
    logic [ZP_W-1:0]   jump_addr;
    logic [SEL_W-1:0]  test_sel;
    logic [DIST_W-1:0] skip_dist;
    logic              cond_hit;
    logic [PC_W-1:0]   pc_inc;

    useq_decode u_decode (
        .ui        (uinstr),
        .kind      (kind),
        .jump_addr (jump_addr),
        .test_sel  (test_sel),
        .skip_dist (skip_dist)
    );

    useq_flag_sel u_flag_sel (
        .flags (flags),
        .sel   (test_sel),
        .hit   (cond_hit)
    );

    // Next-address logic
    always_comb begin
        st_d   = st_q;
        pc_inc = st_q.pc + PC_W'(1);
        case (kind)
            STEP_DISPATCH: st_d.pc = {opcode, {SLOT_W{1'b0}}};
            STEP_JUMP:     st_d.pc = PC_W'(jump_addr);
            STEP_SKIP:     st_d.pc = cond_hit ? pc_inc + PC_W'(skip_dist) : pc_inc;
            default:       st_d.pc = pc_inc;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rom_addr = st_q.pc;

    // Plain step advances by one
    p_plain_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == STEP_NEXT) |=> (rom_addr == $past(rom_addr) + PC_W'(1)));

    // Dispatch lands on the opcode's slot base
    p_dispatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == STEP_DISPATCH) |=> (rom_addr == {$past(opcode), {SLOT_W{1'b0}}}));

    // Zero-page jump lands in the low sixteen words
    p_zero_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == STEP_JUMP) |=> (rom_addr == PC_W'($past(uinstr[ZP_W-1:0]))));

    // Taken skip moves forward by one plus the distance
    p_skip_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (uinstr[UI_W-1 -: 2] == 2'b11 && flags[test_sel]) |=>
        (rom_addr == $past(rom_addr) + PC_W'(1) + PC_W'($past(uinstr[DIST_W-1:0]))));

    // Untaken skip moves by one
    p_skip_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (uinstr[UI_W-1 -: 2] == 2'b11 && !flags[test_sel]) |=>
        (rom_addr == $past(rom_addr) + PC_W'(1)));

    // Top of the address space wraps to zero
    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_addr == {PC_W{1'b1}} && kind == STEP_NEXT) |=> (rom_addr == '0));

endmodule

// File: tb/useq_sequencer_bench.sv
module useq_sequencer_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [11:0] addr;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  uinstr = 8'h00;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  flags = 8'h00;
    logic [11:0] rom_addr;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    exp_t  sb_q[$];
    logic [11:0] model_pc = 12'h000;

    always #(CLK_PERIOD/2) clk = ~clk;

    useq_sequencer u_useq_sequencer (
        .clk      (clk),
        .rst_n    (rst_n),
        .uinstr   (uinstr),
        .opcode   (opcode),
        .flags    (flags),
        .rom_addr (rom_addr)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rom_addr actual 0x%03h expected 0x%03h", req, act, exp);
        end
    endtask

    // Reference next address, written from the requirements
    function automatic logic [11:0] ref_next(input logic [11:0] pc, input logic [7:0] ui,
                                             input logic [7:0] op, input logic [7:0] fl);
        if (ui[7:6] == 2'b11)
            return fl[ui[5:3]] ? pc + 12'd1 + {9'd0, ui[2:0]} : pc + 12'd1;
        if (ui[7:4] == 4'b1011)
            return {op, 4'h0};
        if (ui[7:4] == 4'b1001)
            return {8'h00, ui[3:0]};
        return pc + 12'd1;
    endfunction

    // Driver: applies one microword, queues the expected address
    task automatic step(input logic [7:0] ui, input logic [7:0] op,
                        input logic [7:0] fl, input string req);
        logic [11:0] exp;
        uinstr = ui;
        opcode = op;
        flags  = fl;
        exp    = ref_next(model_pc, ui, op, fl);
        #1;
        check("R9", rom_addr, model_pc);
        @(posedge clk);
        sb_q.push_back('{addr: exp, req: req});
        model_pc = exp;
        @(negedge clk);
    endtask

    // Monitor: compares the register against the scoreboard
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.req, rom_addr, e.addr);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", rom_addr, 12'h000);
        rst_n = 1'b1;
        model_pc = 12'h000;

        // R2: assorted plain microwords
        step(8'h00, 8'h00, 8'h00, "R2");
        step(8'h55, 8'h00, 8'hFF, "R2");
        step(8'h8F, 8'h00, 8'h00, "R2");
        step(8'hA3, 8'h00, 8'h00, "R2");
        step(8'h7E, 8'h00, 8'h00, "R2");

        // R3: dispatch, low nibble ignored
        step(8'hB7, 8'h3C, 8'h00, "R3");
        step(8'h00, 8'h3C, 8'h00, "R2");

        // R5 / R6 / R7: skips
        step(8'hEB, 8'h00, 8'b0010_0000, "R5");
        step(8'hEB, 8'h00, 8'b1101_1111, "R7");
        step(8'hC0, 8'h00, 8'h01, "R5");
        step(8'hFF, 8'h00, 8'h80, "R5");
        step(8'hFF, 8'h00, 8'h7F, "R6");
        for (int s = 0; s < 8; s++) begin
            step(8'hC0 | 8'(s << 3) | 8'h05, 8'h00, 8'(1 << s), "R5");
            step(8'hC0 | 8'(s << 3) | 8'h05, 8'h00, ~8'(1 << s), "R7");
        end

        // R4: zero-page jumps
        step(8'h9A, 8'h77, 8'h00, "R4");
        step(8'h9F, 8'h77, 8'h00, "R4");
        step(8'h90, 8'h77, 8'h00, "R4");

        // R8: wrap by plain advance
        step(8'hB0, 8'hFF, 8'h00, "R3");
        for (int k = 0; k < 15; k++) step(8'h01, 8'h00, 8'h00, "R2");
        step(8'h01, 8'h00, 8'h00, "R8");

        // R8: wrap by taken skip (0xFFE + 1 + 3)
        step(8'hBF, 8'hFF, 8'h00, "R3");
        for (int k = 0; k < 14; k++) step(8'h02, 8'h00, 8'h00, "R2");
        step(8'hD3, 8'h00, 8'h04, "R8");

        // R3: dispatch on opcode zero
        step(8'hB5, 8'h00, 8'h00, "R3");

        // R1: reset in the middle of a routine
        step(8'hB0, 8'h55, 8'h00, "R3");
        rst_n = 1'b0;
        #1;
        check("R1", rom_addr, 12'h000);
        @(negedge clk);
        check("R1", rom_addr, 12'h000);
        rst_n = 1'b1;
        model_pc = 12'h000;
        step(8'h00, 8'h00, 8'h00, "R2");

        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule